// File: doc/BRIEF.md
# Accumulator CPU Sequencing Controller

This block is the control unit of a small 8-bit accumulator processor whose program and data share one 16-word memory. A hand-written finite state machine takes the place of a microcode lookup memory. Each instruction starts with two fetch cycles. An execute phase follows, and its length depends on the opcode, from zero to three cycles. After that, control goes back to fetch. A halt instruction parks the unit until reset.

Every control strobe is decoded combinationally from the current state alone. The datapath latches on the rising clock edge, except for the program counter, which the datapath clocks on the falling edge. Because of this, the increment requested during the instruction-load cycle has taken effect before the next instruction's address phase. This removes a separate increment cycle.

Instruction words have 8 bits. The upper nibble is the opcode and the lower nibble is a memory address or an immediate. The unit has no data stream. All its pins are plain control and status lines, with no handshake.

Top module: `cpu_ctl`

## Requirements
- R1: While `rst` is high at a rising edge, the unit enters the address-fetch state on that edge. In that state only `pc_oe` and `mar_load` are high, and `halted` is low.
- R2: The address-fetch state is always followed by the instruction-load state. In the instruction-load state only `ram_oe`, `ir_load` and `pc_inc` are high.
- R3: Opcode codes are NOP=0, LDA=1, ADD=2, SUB=3, STA=4, LDI=5, JMP=6, JC=7, JZ=8, OUT=14 and HLT=15. Codes 9 to 13 act as NOP. `opcode` is sampled in the instruction-load state, where it must carry the upper nibble of the word being loaded, and it must stay stable until the next fetch. After a NOP, the next cycle is address-fetch.
- R4: LDA runs two steps: `ir_oe`+`mar_load`, then `ram_oe`+`a_load`.
- R5: ADD and SUB run three steps: `ir_oe`+`mar_load`, then `ram_oe`+`b_load`, then `alu_oe`+`a_load`+`flags_load`. For SUB only, `alu_sub` is also high in the third step.
- R6: STA runs two steps: `ir_oe`+`mar_load`, then `a_oe`+`ram_write`.
- R7: LDI runs one step, `ir_oe`+`a_load`. OUT runs one step, `a_oe`+`out_load`.
- R8: JMP runs one step, `ir_oe`+`pc_load`.
- R9: JC runs the `ir_oe`+`pc_load` step only when `flag_carry` is 1. JZ runs it only when `flag_zero` is 1. When the flag is 0, the cycle after instruction-load is address-fetch.
- R10: After HLT, `halted` is 1 and every other output is 0 on every later cycle until reset.
- R11: At most one of the bus drivers `pc_oe`, `ram_oe`, `ir_oe`, `a_oe` and `alu_oe` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Upper nibble of the instruction (see R3 for timing) |
| flag_zero | input | 1 | Latched ALU zero flag |
| flag_carry | input | 1 | Latched ALU carry flag |
| pc_oe | output | 1 | Program counter drives the bus |
| mar_load | output | 1 | Memory address register loads from the bus |
| ram_oe | output | 1 | Memory word drives the bus |
| ir_load | output | 1 | Instruction register loads from the bus |
| pc_inc | output | 1 | Program counter increments on the falling edge |
| ir_oe | output | 1 | Instruction operand nibble drives the bus |
| a_load | output | 1 | Accumulator loads from the bus |
| a_oe | output | 1 | Accumulator drives the bus |
| b_load | output | 1 | Operand register B loads from the bus |
| alu_oe | output | 1 | ALU result drives the bus |
| alu_sub | output | 1 | ALU subtracts instead of adding |
| flags_load | output | 1 | Zero and carry flags latch |
| ram_write | output | 1 | Memory writes the bus at the addressed word |
| out_load | output | 1 | Output register loads from the bus |
| pc_load | output | 1 | Program counter loads the bus low nibble on the falling edge |
| halted | output | 1 | Unit is parked in the halt state |

## Verification
Every strobe is a function of the current state. A change in state appears on the outputs in the cycle right after the rising edge that caused it, so each expected strobe word belongs to one specific cycle. The bench holds an instruction-level model that queues one expected word per cycle for each instruction, and it compares the outputs at every falling edge against the head of that queue. Effects that appear one edge later are checked after the program ends: accumulator values written by OUT, and the program-counter jumps that select which instruction comes next. The reset state is checked on the falling edge after the first reset edge.

// File: rtl/cpu_ctl_pkg.sv
package cpu_ctl_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_NOP = 4'd0;
  localparam logic [OPC_W-1:0] OPC_LDA = 4'd1;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'd2;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'd3;
  localparam logic [OPC_W-1:0] OPC_STA = 4'd4;
  localparam logic [OPC_W-1:0] OPC_LDI = 4'd5;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'd6;
  localparam logic [OPC_W-1:0] OPC_JC  = 4'd7;
  localparam logic [OPC_W-1:0] OPC_JZ  = 4'd8;
  localparam logic [OPC_W-1:0] OPC_OUT = 4'd14;
  localparam logic [OPC_W-1:0] OPC_HLT = 4'd15;

  typedef enum logic [3:0] {
    ST_FETCH_ADDR,
    ST_FETCH_INSN,
    ST_OPND_ADDR,
    ST_LOAD_A,
    ST_LOAD_B,
    ST_WB_ADD,
    ST_WB_SUB,
    ST_STORE,
    ST_LOAD_IMM,
    ST_SHOW,
    ST_JUMP,
    ST_HALT
  } state_e;

  typedef struct packed {
    logic pc_oe;
    logic mar_load;
    logic ram_oe;
    logic ir_load;
    logic pc_inc;
    logic ir_oe;
    logic a_load;
    logic a_oe;
    logic b_load;
    logic alu_oe;
    logic alu_sub;
    logic flags_load;
    logic ram_write;
    logic out_load;
    logic pc_load;
    logic halted;
  } strobes_t;
endpackage

// File: rtl/ctl_seq.sv
module ctl_seq
  import cpu_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             flag_zero,
  input  logic             flag_carry,
  output state_e           state
);
  state_e nxt;

  // Dispatch after the instruction word lands in the IR
  function automatic state_e dispatch(input logic [OPC_W-1:0] op,
                                      input logic zf, input logic cf);
    state_e s;
    case (op)
      OPC_LDA, OPC_ADD, OPC_SUB, OPC_STA: s = ST_OPND_ADDR;
      OPC_LDI: s = ST_LOAD_IMM;
      OPC_JMP: s = ST_JUMP;
      OPC_JC:  s = cf ? ST_JUMP : ST_FETCH_ADDR;
      OPC_JZ:  s = zf ? ST_JUMP : ST_FETCH_ADDR;
      OPC_OUT: s = ST_SHOW;
      OPC_HLT: s = ST_HALT;
      default: s = ST_FETCH_ADDR;  // NOP and unassigned codes
    endcase
    return s;
  endfunction

  always_comb begin
    case (state)
      ST_FETCH_ADDR: nxt = ST_FETCH_INSN;
      ST_FETCH_INSN: nxt = dispatch(opcode, flag_zero, flag_carry);
      ST_OPND_ADDR: begin
        if (opcode == OPC_LDA)      nxt = ST_LOAD_A;
        else if (opcode == OPC_STA) nxt = ST_STORE;
        else                        nxt = ST_LOAD_B;
      end
      ST_LOAD_B: nxt = (opcode == OPC_SUB) ? ST_WB_SUB : ST_WB_ADD;
      ST_HALT:   nxt = ST_HALT;
      default:   nxt = ST_FETCH_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH_ADDR;
    else     state <= nxt;
  end
endmodule

// File: rtl/ctl_strobe_dec.sv
module ctl_strobe_dec
  import cpu_ctl_pkg::*;
(
  input  state_e   state,
  output strobes_t sb
);
  always_comb begin
    sb = '0;
    case (state)
      ST_FETCH_ADDR: begin sb.pc_oe  = 1'b1; sb.mar_load = 1'b1; end
      ST_FETCH_INSN: begin
        sb.ram_oe = 1'b1; sb.ir_load = 1'b1; sb.pc_inc = 1'b1;
      end
      ST_OPND_ADDR:  begin sb.ir_oe  = 1'b1; sb.mar_load = 1'b1; end
      ST_LOAD_A:     begin sb.ram_oe = 1'b1; sb.a_load   = 1'b1; end
      ST_LOAD_B:     begin sb.ram_oe = 1'b1; sb.b_load   = 1'b1; end
      ST_WB_ADD: begin
        sb.alu_oe = 1'b1; sb.a_load = 1'b1; sb.flags_load = 1'b1;
      end
      ST_WB_SUB: begin
        sb.alu_oe = 1'b1; sb.a_load = 1'b1; sb.flags_load = 1'b1;
        sb.alu_sub = 1'b1;
      end
      ST_STORE:      begin sb.a_oe  = 1'b1; sb.ram_write = 1'b1; end
      ST_LOAD_IMM:   begin sb.ir_oe = 1'b1; sb.a_load    = 1'b1; end
      ST_SHOW:       begin sb.a_oe  = 1'b1; sb.out_load  = 1'b1; end
      ST_JUMP:       begin sb.ir_oe = 1'b1; sb.pc_load   = 1'b1; end
      ST_HALT:       sb.halted = 1'b1;
      default:       sb = '0;
    endcase
  end
endmodule

// File: rtl/cpu_ctl.sv
module cpu_ctl
  import cpu_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             flag_zero,
  input  logic             flag_carry,
  output logic             pc_oe,
  output logic             mar_load,
  output logic             ram_oe,
  output logic             ir_load,
  output logic             pc_inc,
  output logic             ir_oe,
  output logic             a_load,
  output logic             a_oe,
  output logic             b_load,
  output logic             alu_oe,
  output logic             alu_sub,
  output logic             flags_load,
  output logic             ram_write,
  output logic             out_load,
  output logic             pc_load,
  output logic             halted
);
  state_e   state;
  strobes_t sb;

  ctl_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .state      (state)
  );

  ctl_strobe_dec u_dec (
    .state (state),
    .sb    (sb)
  );

  assign pc_oe      = sb.pc_oe;
  assign mar_load   = sb.mar_load;
  assign ram_oe     = sb.ram_oe;
  assign ir_load    = sb.ir_load;
  assign pc_inc     = sb.pc_inc;
  assign ir_oe      = sb.ir_oe;
  assign a_load     = sb.a_load;
  assign a_oe       = sb.a_oe;
  assign b_load     = sb.b_load;
  assign alu_oe     = sb.alu_oe;
  assign alu_sub    = sb.alu_sub;
  assign flags_load = sb.flags_load;
  assign ram_write  = sb.ram_write;
  assign out_load   = sb.out_load;
  assign pc_load    = sb.pc_load;
  assign halted     = sb.halted;
endmodule

// File: rtl/cpu_ctl_chk.sv
module cpu_ctl_chk (
  input logic clk,
  input logic rst,
  input logic pc_oe,
  input logic mar_load,
  input logic ram_oe,
  input logic ir_load,
  input logic pc_inc,
  input logic ir_oe,
  input logic a_load,
  input logic a_oe,
  input logic b_load,
  input logic alu_oe,
  input logic alu_sub,
  input logic flags_load,
  input logic ram_write,
  input logic out_load,
  input logic pc_load,
  input logic halted
);
  assert_reset_fetch_R1: assert property (@(posedge clk)
    rst |=> (pc_oe && mar_load && !halted && !ram_oe && !ir_oe));

  assert_fetch_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (pc_oe && mar_load) |=> (ram_oe && ir_load && pc_inc));

  assert_operand_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (ir_oe && mar_load) |=> ((ram_oe && (a_load || b_load)) || (a_oe && ram_write)));

  assert_alu_writeback_R5: assert property (@(posedge clk) disable iff (rst)
    b_load |=> (alu_oe && a_load && flags_load));

  assert_store_after_addr_R6: assert property (@(posedge clk) disable iff (rst)
    ram_write |-> (a_oe && $past(ir_oe && mar_load)));

  assert_jump_operand_R8: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (ir_oe && !mar_load));

  assert_halt_absorbs_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !pc_oe && !mar_load && !ram_oe && !ir_load && !pc_inc &&
                !ir_oe && !a_load && !a_oe && !b_load && !alu_oe && !alu_sub &&
                !flags_load && !ram_write && !out_load && !pc_load));

  assert_one_driver_R11: assert property (@(posedge clk) disable iff (rst)
    $countones({pc_oe, ram_oe, ir_oe, a_oe, alu_oe}) <= 1);
endmodule

bind cpu_ctl cpu_ctl_chk u_chk (
  .clk(clk), .rst(rst), .pc_oe(pc_oe), .mar_load(mar_load), .ram_oe(ram_oe),
  .ir_load(ir_load), .pc_inc(pc_inc), .ir_oe(ir_oe), .a_load(a_load),
  .a_oe(a_oe), .b_load(b_load), .alu_oe(alu_oe), .alu_sub(alu_sub),
  .flags_load(flags_load), .ram_write(ram_write), .out_load(out_load),
  .pc_load(pc_load), .halted(halted)
);

// File: tb/test_cpu_ctl.sv
module test_cpu_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 400;

  localparam logic [15:0] M_PC_OE = 16'h8000, M_MAR = 16'h4000, M_RAM_OE = 16'h2000,
    M_IR_LD = 16'h1000, M_PC_INC = 16'h0800, M_IR_OE = 16'h0400, M_A_LD = 16'h0200,
    M_A_OE = 16'h0100, M_B_LD = 16'h0080, M_ALU_OE = 16'h0040, M_SUB = 16'h0020,
    M_FLG = 16'h0010, M_WR = 16'h0008, M_OUT = 16'h0004, M_PC_LD = 16'h0002,
    M_HALT = 16'h0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] opcode;
  logic flag_zero, flag_carry;
  logic pc_oe, mar_load, ram_oe, ir_load, pc_inc, ir_oe, a_load, a_oe, b_load;
  logic alu_oe, alu_sub, flags_load, ram_write, out_load, pc_load, halted;

  cpu_ctl i_cpu_ctl (
    .clk(clk), .rst(rst), .opcode(opcode), .flag_zero(flag_zero),
    .flag_carry(flag_carry), .pc_oe(pc_oe), .mar_load(mar_load), .ram_oe(ram_oe),
    .ir_load(ir_load), .pc_inc(pc_inc), .ir_oe(ir_oe), .a_load(a_load),
    .a_oe(a_oe), .b_load(b_load), .alu_oe(alu_oe), .alu_sub(alu_sub),
    .flags_load(flags_load), .ram_write(ram_write), .out_load(out_load),
    .pc_load(pc_load), .halted(halted)
  );

  int checks = 0;
  int errors = 0;

  // ---------------- datapath model driven by the strobes ----------------
  logic [7:0] mem [16];
  logic [3:0] pc, mar;
  logic [7:0] ir, a, b;
  logic       cf, zf;
  logic [8:0] alu;
  logic [7:0] bus;
  logic [7:0] out_log [$];

  always_comb alu = alu_sub ? ({1'b0, a} + {1'b0, ~b} + 9'd1) : ({1'b0, a} + {1'b0, b});

  always_comb begin
    bus = 8'h00;
    if (pc_oe)  bus = {4'h0, pc};
    if (ram_oe) bus = mem[mar];
    if (ir_oe)  bus = {4'h0, ir[3:0]};
    if (a_oe)   bus = a;
    if (alu_oe) bus = alu[7:0];
  end

  assign opcode     = ir_load ? bus[7:4] : ir[7:4];
  assign flag_zero  = zf;
  assign flag_carry = cf;

  always @(posedge clk) begin
    if (rst) begin
      a <= 8'h00; b <= 8'h00; ir <= 8'h00; mar <= 4'h0; cf <= 1'b0; zf <= 1'b0;
    end else begin
      if (mar_load)  mar <= bus[3:0];
      if (ir_load)   ir  <= bus;
      if (a_load)    a   <= bus;
      if (b_load)    b   <= bus;
      if (ram_write) mem[mar] <= bus;
      if (out_load)  out_log.push_back(bus);
      if (flags_load) begin cf <= alu[8]; zf <= (alu[7:0] == 8'h00); end
    end
  end

  always @(negedge clk) begin
    if (rst)          pc <= 4'h0;
    else if (pc_load) pc <= bus[3:0];
    else if (pc_inc)  pc <= pc + 4'd1;
  end

  // ---------------- instruction-level reference model ----------------
  logic [7:0]  r_mem [16];
  int          r_pc;
  int          r_a;
  bit          r_c, r_z, r_halt, r_prev_nop;
  int          r_out [$];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  task automatic push(input logic [15:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic ref_step();
    logic [7:0] insn;
    int opd, s;
    if (r_halt) begin push(M_HALT, "R10"); return; end
    insn = r_mem[r_pc];
    opd  = int'(insn[3:0]);
    push(M_PC_OE | M_MAR, r_prev_nop ? "R3" : "R2");
    push(M_RAM_OE | M_IR_LD | M_PC_INC, "R2");
    r_pc = (r_pc + 1) % 16;
    r_prev_nop = 1'b0;
    case (int'(insn[7:4]))
      1: begin push(M_IR_OE | M_MAR, "R4"); push(M_RAM_OE | M_A_LD, "R4"); r_a = int'(r_mem[opd]); end
      2, 3: begin
        push(M_IR_OE | M_MAR, "R5"); push(M_RAM_OE | M_B_LD, "R5");
        if (insn[7:4] == 4'd3) begin
          push(M_ALU_OE | M_A_LD | M_FLG | M_SUB, "R5");
          s = r_a + (255 - int'(r_mem[opd])) + 1;
        end else begin
          push(M_ALU_OE | M_A_LD | M_FLG, "R5");
          s = r_a + int'(r_mem[opd]);
        end
        r_c = (s > 255); r_a = s % 256; r_z = (r_a == 0);
      end
      4: begin push(M_IR_OE | M_MAR, "R6"); push(M_A_OE | M_WR, "R6"); r_mem[opd] = r_a[7:0]; end
      5: begin push(M_IR_OE | M_A_LD, "R7"); r_a = opd; end
      6: begin push(M_IR_OE | M_PC_LD, "R8"); r_pc = opd; end
      7, 8: begin
        if ((insn[7:4] == 4'd7) ? r_c : r_z) begin push(M_IR_OE | M_PC_LD, "R9"); r_pc = opd; end
        else r_prev_nop = 1'b1;  // not-taken branch: straight back to fetch (R9)
      end
      14: begin push(M_A_OE | M_OUT, "R7"); r_out.push_back(r_a); end
      15: r_halt = 1'b1;
      default: r_prev_nop = 1'b1;
    endcase
  endtask

  function automatic logic [15:0] actual();
    return {pc_oe, mar_load, ram_oe, ir_load, pc_inc, ir_oe, a_load, a_oe, b_load,
            alu_oe, alu_sub, flags_load, ram_write, out_load, pc_load, halted};
  endfunction

  task automatic check(input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s strobes act=%h exp=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic run_prog(input logic [127:0] prog, input string name);
    int halt_cycles;
    logic [15:0] v;
    string t;
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      mem[i]   = prog[127 - 8*i -: 8];
      r_mem[i] = prog[127 - 8*i -: 8];
    end
    r_pc = 0; r_a = 0; r_c = 0; r_z = 0; r_halt = 0; r_prev_nop = 0;
    r_out.delete(); exp_q.delete(); tag_q.delete(); out_log.delete();
    repeat (2) @(negedge clk);
    check("R1", actual(), M_PC_OE | M_MAR);  // reset state, halted low
    rst = 1'b0;
    ref_step();
    void'(exp_q.pop_front()); void'(tag_q.pop_front());  // address fetch seen above
    halt_cycles = 0;
    for (int c = 0; c < MAX_CYC; c++) begin
      @(negedge clk);
      if (exp_q.size() == 0) ref_step();
      v = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, actual(), v);
      if (r_halt && v == M_HALT) halt_cycles++;
      if (halt_cycles >= 5) break;
    end
    checks++;
    if (halt_cycles < 5) begin
      errors++;
      $display("FAIL R10 %s halt cycles act=%0d exp=5", name, halt_cycles);
    end
    checks++;
    if (out_log.size() != r_out.size()) begin
      errors++;
      $display("FAIL R7 %s output count act=%0d exp=%0d", name, out_log.size(), r_out.size());
    end else begin
      foreach (r_out[k]) begin
        checks++;
        if (int'(out_log[k]) != r_out[k]) begin
          errors++;
          $display("FAIL R7 %s output %0d act=%0d exp=%0d", name, k, out_log[k], r_out[k]);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R4 R5 R6 R7 R8 R9 (JC not taken, JZ taken) R3 (undefined code) R10
    run_prog(128'h552EE0763F87E04D1EE0906CF000070C, "p1");
    // loop with JZ not taken, JC taken, self-modified NOP words, HLT from data
    run_prog(128'h533FE085611E2D79F04C1CE00002FF01, "p2");
    // undefined opcodes 9..13 as NOP (R3), reset clears the halt (R1)
    run_prog(128'h9AABBCCDD100F0000000000000000000, "p3");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule